// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command interpreter that sits behind the bus pins of a 16-bit parallel NOR flash. Every host write reaches it as a one-cycle strobe that carries an already latched address and data word. The decoder follows the unlock handshakes that guard every change to the array. When a handshake finishes, it emits one operation pulse. The pulse carries an operation code, the target address aligned to the region being acted on, and the data word where the operation needs one. The array, the program and erase timer and the analog circuits sit outside this block and act on that pulse.

Besides the operation pulse, the decoder holds the current read mode: normal array data, identification, query table or security-ID space. A read multiplexer elsewhere uses this mode. A status block drives two inputs. One says that an internal program or erase is running. The other says that the running operation is an erase. While the first input is high the decoder ignores every write, except a suspend request that arrives during an erase. The decoder itself remembers whether an erase is currently suspended, so that a resume can be accepted.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After a synchronous active-low reset, `op_valid` is 0 and `mode` is 0, which means read array.
- R2: A word program sequence is AAh to 555h, then 55h to 2AAh, then A0h to 555h, followed by one more write. That fourth write gives one `op_valid` pulse with `op_code`=1 and with `op_addr`/`op_data` equal to the address and data of that write. The three unlock writes give no pulse.
- R3: The erase prefix is the five writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh. The sixth write decides the operation. 50h at any address gives `op_code`=2, with the address bits 10..0 cleared (sector). 30h gives `op_code`=3, with bits 14..0 cleared (block). 10h at 555h gives `op_code`=4 with address 0 (chip). For all three erases, `op_data` is 0.
- R4: Command matching looks only at address bits 10..0 and data bits 7..0. The upper address bits and data bits 15..8 do not change which command is decoded.
- R5: The third write of a three-write handshake goes to 555h. If its data is 90h, `mode` becomes 1 (identification). 98h gives 2 (query) and 88h gives 3 (security ID). F0h gives 0 (read array).
- R6: When no sequence is in progress and the block is not busy, a single write of F0h to any address sets `mode` to 0.
- R7: A third-write value of A5h means the next write gives `op_code`=7 (security-ID program), with its address and data. A third-write value of 85h means the next write gives `op_code`=8 (security-ID lock), with its address and with data 0.
- R8: A write of B0h to any address while `busy` and `erasing` are both 1 and no erase is suspended gives `op_code`=5 (suspend), and the erase becomes suspended. Later, when the block is not busy and no sequence is in progress, a single write of 30h gives `op_code`=6 (resume) and clears the suspension. A 30h write gives no pulse when no erase is suspended. Suspend and resume both carry address 0 and data 0.
- R9: While `busy` is 1, every other write is ignored. It gives no pulse, leaves `mode` unchanged (this includes F0h exits) and leaves the sequence position unchanged.
- R10: If a write in the middle of a sequence does not match the expected step, the sequence ends. `mode` becomes 0, the write gives no pulse and it does not start a new sequence.
- R11: The sequence position is kept for any number of cycles without a strobe. Each pulse comes in the cycle right after the strobe that completed its sequence, and a strobe gives at most one pulse.
- R12: Any mix of valid, partial and invalid writes, with `busy` changing at random, gives the outputs that R2 to R11 define, write by write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | One-cycle strobe marking a latched bus write |
| wr_addr | input | 22 | Latched word address of the write |
| wr_data | input | 16 | Latched data word of the write |
| busy | input | 1 | An internal program or erase is running |
| erasing | input | 1 | The running internal operation is an erase |
| op_valid | output | 1 | One-cycle pulse for a decoded operation |
| op_code | output | 4 | Operation code (R2, R3, R7, R8) |
| op_addr | output | 22 | Aligned target address of the operation |
| op_data | output | 16 | Data word of a program operation, else 0 |
| mode | output | 2 | Read mode: 0 array, 1 ID, 2 query, 3 security ID |

## Verification
A wrong sequence position cannot be seen at once. It shows one write later, when a write that should complete or advance a handshake produces no pulse, or a pulse where none belongs, or a `mode` value that falls back to 0 unexpectedly. A wrong suspend flag shows only when a later 30h write produces, or fails to produce, a resume pulse. For that reason the bench checks `op_valid`, `op_code`, `op_addr`, `op_data` and `mode` after every single write, against a model that it steps alongside the design. Long random streams with busy periods push these hidden states into the places where they become visible.

// File: rtl/flash_cmd_pkg.sv
// flash_cmd_pkg: shared encodings for the flash command decoder.
// Assumes an 8-bit command key and 11-bit command addresses.
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_PROG       = 4'd1,
        OP_SECT_ERASE = 4'd2,
        OP_BLK_ERASE  = 4'd3,
        OP_CHIP_ERASE = 4'd4,
        OP_SUSPEND    = 4'd5,
        OP_RESUME     = 4'd6,
        OP_SID_PROG   = 4'd7,
        OP_SID_LOCK   = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        MD_ARRAY = 2'd0,
        MD_IDENT = 2'd1,
        MD_QUERY = 2'd2,
        MD_SECID = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_UNL1,
        SQ_UNL2,
        SQ_PROG_ARG,
        SQ_ER3,
        SQ_ER4,
        SQ_ER5,
        SQ_SIDP_ARG,
        SQ_SIDL_ARG
    } seq_e;

    localparam logic [10:0] CMD_ADDR_A = 11'h555;
    localparam logic [10:0] CMD_ADDR_B = 11'h2AA;

    localparam logic [7:0] KEY_UNL_A   = 8'hAA;
    localparam logic [7:0] KEY_UNL_B   = 8'h55;
    localparam logic [7:0] KEY_PROG    = 8'hA0;
    localparam logic [7:0] KEY_ERASE   = 8'h80;
    localparam logic [7:0] KEY_IDENT   = 8'h90;
    localparam logic [7:0] KEY_QUERY   = 8'h98;
    localparam logic [7:0] KEY_SECID   = 8'h88;
    localparam logic [7:0] KEY_SIDPROG = 8'hA5;
    localparam logic [7:0] KEY_SIDLOCK = 8'h85;
    localparam logic [7:0] KEY_EXIT    = 8'hF0;
    localparam logic [7:0] KEY_SUSPEND = 8'hB0;
    localparam logic [7:0] KEY_RESUME  = 8'h30;
    localparam logic [7:0] KEY_SECT    = 8'h50;
    localparam logic [7:0] KEY_BLK     = 8'h30;
    localparam logic [7:0] KEY_CHIP    = 8'h10;

    // Classification of one write against the unlock patterns.
    typedef struct packed {
        logic       hit_a;   // unlock key A at address A
        logic       hit_b;   // unlock key B at address B
        logic       at_a;    // address equals address A
        logic [7:0] key;     // low data byte
    } wr_class_t;

endpackage

// File: rtl/flash_cmd_classify.sv
// flash_cmd_classify: compares one latched write with the unlock pattern.
// Assumes only the low CMD_AW address bits and low data byte take part.
module flash_cmd_classify
    import flash_cmd_pkg::*;
#(
    parameter int CMD_AW = 11
) (
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_key,
    output wr_class_t         cls
);

    localparam logic [CMD_AW-1:0] ADDR_A = CMD_AW'(CMD_ADDR_A);
    localparam logic [CMD_AW-1:0] ADDR_B = CMD_AW'(CMD_ADDR_B);

    logic at_a;
    logic at_b;

    // Address decode of the two command locations.
    always_comb begin
        at_a = (cmd_addr == ADDR_A);
        at_b = (cmd_addr == ADDR_B);
    end

    // Pack the match flags with the key byte.
    always_comb begin
        cls.hit_a = at_a && (cmd_key == KEY_UNL_A);
        cls.hit_b = at_b && (cmd_key == KEY_UNL_B);
        cls.at_a  = at_a;
        cls.key   = cmd_key;
    end

endmodule

// File: rtl/flash_cmd_seq.sv
// flash_cmd_seq: unlock sequence state machine, read mode and suspend flag.
// Assumes one classified write per wr_stb; holds position between strobes.
module flash_cmd_seq
    import flash_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_stb,
    input  wr_class_t cls,
    input  logic      busy,
    input  logic      erasing,
    output logic      fire,
    output op_e       fire_op,
    output mode_e     mode_q
);

    seq_e  state_q, state_d;
    mode_e mode_d;
    logic  susp_q, susp_d;

    // Next-state decision for one strobed write.
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        susp_d  = susp_q;
        fire    = 1'b0;
        fire_op = OP_NONE;
        if (wr_stb) begin
            if (busy) begin
                if (erasing && !susp_q && cls.key == KEY_SUSPEND) begin
                    fire    = 1'b1;
                    fire_op = OP_SUSPEND;
                    susp_d  = 1'b1;
                end
            end else begin
                case (state_q)
                    SQ_IDLE: begin
                        if (cls.key == KEY_EXIT) begin
                            mode_d = MD_ARRAY;
                        end else if (cls.key == KEY_RESUME && susp_q) begin
                            fire    = 1'b1;
                            fire_op = OP_RESUME;
                            susp_d  = 1'b0;
                        end else if (cls.hit_a) begin
                            state_d = SQ_UNL1;
                        end
                    end
                    SQ_UNL1: begin
                        if (cls.hit_b) begin
                            state_d = SQ_UNL2;
                        end else begin
                            state_d = SQ_IDLE;
                            mode_d  = MD_ARRAY;
                        end
                    end
                    SQ_UNL2: begin
                        state_d = SQ_IDLE;
                        if (!cls.at_a) begin
                            mode_d = MD_ARRAY;
                        end else begin
                            case (cls.key)
                                KEY_PROG:    state_d = SQ_PROG_ARG;
                                KEY_ERASE:   state_d = SQ_ER3;
                                KEY_IDENT:   mode_d  = MD_IDENT;
                                KEY_QUERY:   mode_d  = MD_QUERY;
                                KEY_SECID:   mode_d  = MD_SECID;
                                KEY_SIDPROG: state_d = SQ_SIDP_ARG;
                                KEY_SIDLOCK: state_d = SQ_SIDL_ARG;
                                default:     mode_d  = MD_ARRAY;
                            endcase
                        end
                    end
                    SQ_PROG_ARG: begin
                        state_d = SQ_IDLE;
                        fire    = 1'b1;
                        fire_op = OP_PROG;
                    end
                    SQ_ER3: begin
                        if (cls.hit_a) begin
                            state_d = SQ_ER4;
                        end else begin
                            state_d = SQ_IDLE;
                            mode_d  = MD_ARRAY;
                        end
                    end
                    SQ_ER4: begin
                        if (cls.hit_b) begin
                            state_d = SQ_ER5;
                        end else begin
                            state_d = SQ_IDLE;
                            mode_d  = MD_ARRAY;
                        end
                    end
                    SQ_ER5: begin
                        state_d = SQ_IDLE;
                        if (cls.key == KEY_SECT) begin
                            fire    = 1'b1;
                            fire_op = OP_SECT_ERASE;
                        end else if (cls.key == KEY_BLK) begin
                            fire    = 1'b1;
                            fire_op = OP_BLK_ERASE;
                        end else if (cls.key == KEY_CHIP && cls.at_a) begin
                            fire    = 1'b1;
                            fire_op = OP_CHIP_ERASE;
                        end else begin
                            mode_d = MD_ARRAY;
                        end
                    end
                    SQ_SIDP_ARG: begin
                        state_d = SQ_IDLE;
                        fire    = 1'b1;
                        fire_op = OP_SID_PROG;
                    end
                    SQ_SIDL_ARG: begin
                        state_d = SQ_IDLE;
                        fire    = 1'b1;
                        fire_op = OP_SID_LOCK;
                    end
                    default: begin
                        state_d = SQ_IDLE;
                        mode_d  = MD_ARRAY;
                    end
                endcase
            end
        end
    end

    // State, mode and suspend registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            mode_q  <= MD_ARRAY;
            susp_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            susp_q  <= susp_d;
        end
    end

    // R9: a busy write leaves the read mode alone.
    p_mode_hold_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mode_q));

    // R11: with no strobe, position and mode are kept.
    p_hold_no_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(state_q) && $stable(mode_q)));

endmodule

// File: rtl/flash_cmd_outreg.sv
// flash_cmd_outreg: registers the operation pulse and aligns its address.
// Assumes fire comes from the same cycle as wr_stb and the latched bus.
module flash_cmd_outreg
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int SECT_AW = 11,
    parameter int BLK_AW  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              fire,
    input  op_e               fire_op,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              op_valid,
    output op_e               op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    localparam logic [ADDR_W-1:0] SECT_MASK = ~((ADDR_W'(1) << SECT_AW) - ADDR_W'(1));
    localparam logic [ADDR_W-1:0] BLK_MASK  = ~((ADDR_W'(1) << BLK_AW) - ADDR_W'(1));

    logic [ADDR_W-1:0] addr_d;
    logic [DATA_W-1:0] data_d;

    // Address alignment and data selection per operation.
    always_comb begin
        case (fire_op)
            OP_SECT_ERASE: addr_d = wr_addr & SECT_MASK;
            OP_BLK_ERASE:  addr_d = wr_addr & BLK_MASK;
            OP_PROG, OP_SID_PROG, OP_SID_LOCK: addr_d = wr_addr;
            default:       addr_d = '0;
        endcase
        data_d = (fire_op == OP_PROG || fire_op == OP_SID_PROG) ? wr_data : '0;
    end

    // Output pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_valid <= 1'b0;
            op_code  <= OP_NONE;
            op_addr  <= '0;
            op_data  <= '0;
        end else begin
            op_valid <= fire;
            op_code  <= fire ? fire_op : OP_NONE;
            op_addr  <= fire ? addr_d : '0;
            op_data  <= fire ? data_d : '0;
        end
    end

    // R11: a pulse only follows a strobe.
    p_pulse_after_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> $past(wr_stb));

endmodule

// File: rtl/flash_cmd_decoder.sv
// flash_cmd_decoder: top of the parallel flash command interpreter.
// Assumes writes arrive as one-cycle strobes with address and data latched.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int DATA_W  = 16,
    parameter int CMD_AW  = 11,
    parameter int SECT_AW = 11,
    parameter int BLK_AW  = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              erasing,
    output logic              op_valid,
    output logic [3:0]        op_code,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [1:0]        mode
);

    wr_class_t cls;
    logic      fire;
    op_e       fire_op;
    mode_e     mode_q;
    op_e       op_code_e;

    flash_cmd_classify #(.CMD_AW(CMD_AW)) u_classify (
        .cmd_addr (wr_addr[CMD_AW-1:0]),
        .cmd_key  (wr_data[7:0]),
        .cls      (cls)
    );

    flash_cmd_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .cls     (cls),
        .busy    (busy),
        .erasing (erasing),
        .fire    (fire),
        .fire_op (fire_op),
        .mode_q  (mode_q)
    );

    flash_cmd_outreg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SECT_AW (SECT_AW),
        .BLK_AW  (BLK_AW)
    ) u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .fire     (fire),
        .fire_op  (fire_op),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .op_valid (op_valid),
        .op_code  (op_code_e),
        .op_addr  (op_addr),
        .op_data  (op_data)
    );

    // Port mapping of enum-typed internals.
    always_comb begin
        op_code = op_code_e;
        mode    = mode_q;
    end

    // R9: busy writes outside an erase never produce an operation.
    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && busy && !erasing) |=> !op_valid);

    // R8: a suspend pulse comes only from a write during a running erase.
    p_suspend_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd5) |-> $past(busy && erasing && wr_stb));

    // R3: a sector erase keeps the sector bits of the strobed address.
    p_sector_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd2) |->
        (op_addr[ADDR_W-1:SECT_AW] == $past(wr_addr[ADDR_W-1:SECT_AW])));

endmodule

// File: tb/flash_cmd_decoder_tb.sv
// Self-checking bench: directed sequences followed by seeded random writes.
module flash_cmd_decoder_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_stb = 1'b0;
    logic [21:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        busy = 1'b0;
    logic        erasing = 1'b0;
    logic        op_valid;
    logic [3:0]  op_code;
    logic [21:0] op_addr;
    logic [15:0] op_data;
    logic [1:0]  mode;

    int n_chk = 0;
    int n_bad = 0;

    // Bench model state
    int          mst = 0;
    logic [1:0]  mmode = 2'd0;
    logic        msusp = 1'b0;
    logic        ev;
    logic [3:0]  ec;
    logic [21:0] ea;
    logic [15:0] ed;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .erasing(erasing),
        .op_valid(op_valid), .op_code(op_code), .op_addr(op_addr),
        .op_data(op_data), .mode(mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_abort();
        mst   = 0;
        mmode = 2'd0;
    endtask

    // Expected behaviour of one write, from the requirements.
    task automatic model_step(input logic [21:0] a, input logic [15:0] d,
                              input logic b, input logic e);
        logic [7:0] k;
        logic c5;
        logic c2;
        k  = d[7:0];
        c5 = (a[10:0] == 11'h555);
        c2 = (a[10:0] == 11'h2AA);
        ev = 1'b0; ec = 4'd0; ea = '0; ed = '0;
        if (b) begin
            if (e && !msusp && k == 8'hB0) begin
                ev = 1'b1; ec = 4'd5; msusp = 1'b1;
            end
        end else begin
            case (mst)
                0: begin
                    if (k == 8'hF0) mmode = 2'd0;
                    else if (k == 8'h30 && msusp) begin
                        ev = 1'b1; ec = 4'd6; msusp = 1'b0;
                    end else if (c5 && k == 8'hAA) mst = 1;
                end
                1: if (c2 && k == 8'h55) mst = 2; else model_abort();
                2: begin
                    mst = 0;
                    if (!c5) mmode = 2'd0;
                    else case (k)
                        8'hA0: mst = 3;
                        8'h80: mst = 4;
                        8'h90: mmode = 2'd1;
                        8'h98: mmode = 2'd2;
                        8'h88: mmode = 2'd3;
                        8'hA5: mst = 7;
                        8'h85: mst = 8;
                        default: mmode = 2'd0;
                    endcase
                end
                3: begin mst = 0; ev = 1'b1; ec = 4'd1; ea = a; ed = d; end
                4: if (c5 && k == 8'hAA) mst = 5; else model_abort();
                5: if (c2 && k == 8'h55) mst = 6; else model_abort();
                6: begin
                    mst = 0;
                    if (k == 8'h50) begin ev = 1'b1; ec = 4'd2; ea = {a[21:11], 11'b0}; end
                    else if (k == 8'h30) begin ev = 1'b1; ec = 4'd3; ea = {a[21:15], 15'b0}; end
                    else if (k == 8'h10 && c5) begin ev = 1'b1; ec = 4'd4; end
                    else mmode = 2'd0;
                end
                7: begin mst = 0; ev = 1'b1; ec = 4'd7; ea = a; ed = d; end
                8: begin mst = 0; ev = 1'b1; ec = 4'd8; ea = a; end
                default: model_abort();
            endcase
        end
    endtask

    // Drive one strobed write and compare every output one cycle later.
    task automatic wr(input string tag, input logic [21:0] a, input logic [15:0] d,
                      input logic b = 1'b0, input logic e = 1'b0);
        @(negedge clk);
        wr_stb = 1'b1; wr_addr = a; wr_data = d; busy = b; erasing = e;
        model_step(a, d, b, e);
        @(negedge clk);
        wr_stb = 1'b0; busy = 1'b0; erasing = 1'b0;
        check(tag, "op_valid", 32'(op_valid), 32'(ev));
        if (ev) begin
            check(tag, "op_code", 32'(op_code), 32'(ec));
            check(tag, "op_addr", 32'(op_addr), 32'(ea));
            check(tag, "op_data", 32'(op_data), 32'(ed));
        end
        check(tag, "mode", 32'(mode), 32'(mmode));
    endtask

    task automatic unlock3(input string tag, input logic [7:0] k);
        wr(tag, 22'h000555, 16'h00AA);
        wr(tag, 22'h0002AA, 16'h0055);
        wr(tag, 22'h000555, {8'h00, k});
    endtask

    task automatic erase_prefix(input string tag);
        unlock3(tag, 8'h80);
        wr(tag, 22'h000555, 16'h00AA);
        wr(tag, 22'h0002AA, 16'h0055);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog R12 actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] keys [14];
        keys = '{8'hAA, 8'h55, 8'hA0, 8'h80, 8'h90, 8'h98, 8'h88,
                 8'hA5, 8'h85, 8'hF0, 8'hB0, 8'h30, 8'h50, 8'h10};
        void'($urandom(32'h5EED1));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "op_valid", 32'(op_valid), 32'd0);
        check("R1", "mode", 32'(mode), 32'd0);

        // R2: word program
        unlock3("R2", 8'hA0);
        wr("R2", 22'h123456, 16'hBEEF);
        check("R2", "direct addr", 32'(op_addr), 32'h123456);

        // R3: sector, block and chip erase
        erase_prefix("R3");
        wr("R3", 22'h2ABCDE, 16'h0050);
        check("R3", "sector aligned", 32'(op_addr), 32'h2AB800);
        erase_prefix("R3");
        wr("R3", 22'h3FFFFF, 16'h0030);
        check("R3", "block aligned", 32'(op_addr), 32'h3F8000);
        erase_prefix("R3");
        wr("R3", 22'h000555, 16'h0010);
        check("R3", "chip code", 32'(op_code), 32'd4);

        // R4: upper address and data bits are ignored
        wr("R4", 22'h3FF555, 16'hFFAA);
        wr("R4", 22'h2A82AA, 16'h3355);
        wr("R4", 22'h155555, 16'h12A0);
        wr("R4", 22'h001234, 16'h5A5A);
        check("R4", "prog code", 32'(op_code), 32'd1);

        // R5: mode entries and 3-write exit
        unlock3("R5", 8'h90);
        unlock3("R5", 8'h98);
        unlock3("R5", 8'h88);
        check("R5", "secid mode", 32'(mode), 32'd3);
        unlock3("R5", 8'hF0);

        // R6: single exit at any address
        unlock3("R6", 8'h90);
        wr("R6", 22'h2F1234, 16'h77F0);
        check("R6", "array mode", 32'(mode), 32'd0);

        // R7: security-ID program and lock
        unlock3("R7", 8'hA5);
        wr("R7", 22'h000013, 16'hC0DE);
        unlock3("R7", 8'h85);
        wr("R7", 22'h000000, 16'h0000);

        // R8: suspend during erase, then resume, then a stray resume
        wr("R8", 22'h0ABCDE, 16'h00B0, 1'b1, 1'b1);
        check("R8", "suspend code", 32'(op_code), 32'd5);
        wr("R8", 22'h000777, 16'h0030);
        check("R8", "resume code", 32'(op_code), 32'd6);
        wr("R8", 22'h000777, 16'h0030);
        wr("R8", 22'h000001, 16'h00B0);

        // R9: busy writes ignored, sequence position kept
        unlock3("R9", 8'h98);
        wr("R9", 22'h000555, 16'h00F0, 1'b1, 1'b0);
        check("R9", "mode kept", 32'(mode), 32'd2);
        wr("R9", 22'h000000, 16'h00B0, 1'b1, 1'b0);
        wr("R9", 22'h000555, 16'h00AA);
        wr("R9", 22'h0002AA, 16'h0012, 1'b1, 1'b1);
        wr("R9", 22'h0002AA, 16'h0055);
        wr("R9", 22'h000555, 16'h0090);
        check("R9", "ident after busy gap", 32'(mode), 32'd1);

        // R10: abort mid-sequence
        wr("R10", 22'h000555, 16'h00AA);
        wr("R10", 22'h0002AA, 16'h0012);
        check("R10", "aborted to array", 32'(mode), 32'd0);
        wr("R10", 22'h0002AA, 16'h0055);
        wr("R10", 22'h000555, 16'h0090);
        check("R10", "no ident", 32'(mode), 32'd0);
        erase_prefix("R10");
        wr("R10", 22'h000444, 16'h0010);

        // R11: position held over a long idle gap
        wr("R11", 22'h000555, 16'h00AA);
        repeat (50) @(negedge clk);
        check("R11", "no pulse in gap", 32'(op_valid), 32'd0);
        wr("R11", 22'h0002AA, 16'h0055);
        repeat (20) @(negedge clk);
        wr("R11", 22'h000555, 16'h0098);
        check("R11", "query", 32'(mode), 32'd2);

        // R12: random mix
        for (int i = 0; i < 800; i++) begin
            logic [21:0] a;
            logic [15:0] d;
            logic        b;
            logic        e;
            int          sel;
            a   = 22'($urandom);
            sel = int'($urandom % 4);
            if (sel == 0) a[10:0] = 11'h555;
            else if (sel == 1) a[10:0] = 11'h2AA;
            d = {8'($urandom), keys[$urandom % 14]};
            if ($urandom % 10 == 0) d[7:0] = 8'($urandom);
            b = ($urandom % 5 == 0);
            e = b && ($urandom % 2 == 0);
            wr("R12", a, d, b, e);
            if ($urandom % 8 == 0) repeat (int'($urandom % 4)) @(negedge clk);
        end

        summary();
        $finish;
    end

endmodule